// File: doc/BRIEF.md
# Tiny 8-bit Register Processor Core

This block is a small single-issue processor core with an 8-bit datapath. Every instruction is one byte, and the core fetches, decodes and executes it in a single clock cycle. The state is small: four general registers, a program counter, a one-bit equality flag, an 8-bit immediate register that is built one nibble at a time, and a saved return address for one interrupt level. The core reads the instruction at the program counter combinationally from an instruction port. It reaches data memory through an address, a write-data bus, a write strobe and a combinational read-data input.

The immediate register has no separate operand path. When an instruction names index 3 as its source, the operand is the immediate register, so a program builds a constant with two nibble loads and then uses it as an operand, an address or a jump target. As a destination, index 3 still names general register r3. A single interrupt request is taken between instructions while it is unmasked. The interrupted instruction finishes, and its successor address is kept for the interrupt return.

Top module: `tiny8_core`

## Requirements
- R1: A synchronous active-low reset sets the program counter, the flag, all four registers, the immediate register and the interrupt mask to zero. After reset, interrupts are enabled.
- R2: Instruction bits [7:4] hold the opcode, bits [3:2] the destination index and bits [1:0] the source index. Opcode 0 copies the source into the destination. Opcode 5 writes the bitwise inverse of the source into the destination.
- R3: Opcodes 1, 2, 3 and 4 write destination+source, destination-source, destination AND source and destination OR source into the destination. All results are modulo 256.
- R4: Opcode 6 shifts the destination left logically, opcode 7 shifts it right logically and opcode 8 shifts it right arithmetically, each by the source value. For an amount of 8 or more, the logical shifts give 0 and the arithmetic shift gives eight copies of the sign bit.
- R5: Source index 3 reads the immediate register. Destination index 3 reads and writes general register r3.
- R6: Opcode 12 writes instruction bits [3:0] into the upper nibble of the immediate register. Opcode 13 writes them into the lower nibble. The other nibble is unchanged.
- R7: Opcode 9 sets the flag when the destination equals the source and clears it otherwise. It writes no register.
- R8: Opcode 10 with bits [3:2]=00 loads the PC with the source when the flag is set, and otherwise advances it by one. Opcode 11 with bits [3:2]=00 always loads the PC with the source.
- R9: Every other encoding under opcodes 10 and 11, except 0xB4, is a no-op that advances the PC by one.
- R10: Opcode 14 loads the destination from data memory. Opcode 15 stores the destination to data memory. Both use the source value as the address. The write strobe is high only for opcode 15, and the write data is the destination value.
- R11: When the request is high and interrupts are unmasked, the current instruction completes. Its next PC goes into the return-address register, the PC becomes the vector (default 0xF0) and interrupts are masked.
- R12: Encoding 0xB4 loads the PC from the return-address register and unmasks interrupts.
- R13: All instructions other than taken jumps and the interrupt return advance the PC by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_addr | output | 8 | Program counter, used as the instruction fetch address |
| instr_data | input | 8 | Instruction byte at instr_addr |
| dmem_addr | output | 8 | Data memory address (source operand) |
| dmem_wdata | output | 8 | Data memory write data (destination operand) |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_rdata | input | 8 | Data memory read data at dmem_addr |
| irq | input | 1 | Interrupt request |

## Verification
The hardest case to reach is an interrupt taken on a jump, followed by a return to the jump target rather than to the next sequential address. The same sequence must also show that a request held high stays masked until the return executes. The bench drives instruction bytes straight onto the fetch port, which lets it place a jump in the same cycle as a raised request. It then issues a still-pending request and the return and compares the fetch address at each step. Operand values are loaded through the immediate path and read back through stores, and a sweep over operand pairs covers shift amounts on both sides of 8 as well as sign-bit cases.

// File: rtl/tiny8_pkg.sv
// Package: shared opcode encoding and decoded-control bundle for the tiny8 core.
// Assumes an 8-bit instruction with a 4-bit opcode and two 2-bit register fields.
package tiny8_pkg;

    typedef enum logic [3:0] {
        OP_MOV   = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_AND   = 4'd3,
        OP_OR    = 4'd4,
        OP_NOT   = 4'd5,
        OP_SLL   = 4'd6,
        OP_SRL   = 4'd7,
        OP_SRA   = 4'd8,
        OP_CMP   = 4'd9,
        OP_JEQ   = 4'd10,
        OP_JMP   = 4'd11,
        OP_IMMHI = 4'd12,
        OP_IMMLO = 4'd13,
        OP_LOAD  = 4'd14,
        OP_STORE = 4'd15
    } opcode_e;

    // Register index field width and count are fixed by the encoding.
    localparam int IDX_W   = 2;
    localparam int NREG    = 1 << IDX_W;
    localparam logic [IDX_W-1:0] IMM_IDX = IDX_W'(NREG - 1);

    // Low nibble that marks the interrupt return under the jump opcode.
    localparam logic [3:0] RETI_LOW = 4'b0100;

    typedef struct packed {
        opcode_e op;
        logic    rf_we;
        logic    from_mem;
        logic    is_cmp;
        logic    is_je;
        logic    is_jmp;
        logic    is_iret;
        logic    is_ldih;
        logic    is_ldil;
        logic    is_st;
    } ctrl_t;

endpackage

// File: rtl/tiny8_decode.sv
// Module: instruction decoder. Splits the byte into opcode, register indices and
// immediate nibble, and produces control strobes. Purely combinational.
// Assumes: undefined encodings under the branch opcodes decode to no-ops.
module tiny8_decode
    import tiny8_pkg::*;
(
    input  logic [7:0]       instr,
    output ctrl_t            ctl,
    output logic [IDX_W-1:0] dsel,
    output logic [IDX_W-1:0] ssel,
    output logic [3:0]       imm4
);

    assign dsel = instr[3:2];
    assign ssel = instr[1:0];
    assign imm4 = instr[3:0];

    // Map the opcode to its control strobes.
    always_comb begin
        ctl          = '0;
        ctl.op       = opcode_e'(instr[7:4]);
        unique case (ctl.op)
            OP_MOV, OP_ADD, OP_SUB, OP_AND, OP_OR,
            OP_NOT, OP_SLL, OP_SRL, OP_SRA: ctl.rf_we = 1'b1;
            OP_CMP:   ctl.is_cmp = 1'b1;
            OP_JEQ:   ctl.is_je  = (instr[3:2] == 2'b00);
            OP_JMP: begin
                ctl.is_jmp  = (instr[3:2] == 2'b00);
                ctl.is_iret = (instr[3:0] == RETI_LOW);
            end
            OP_IMMHI: ctl.is_ldih = 1'b1;
            OP_IMMLO: ctl.is_ldil = 1'b1;
            OP_LOAD: begin
                ctl.rf_we    = 1'b1;
                ctl.from_mem = 1'b1;
            end
            OP_STORE: ctl.is_st = 1'b1;
            default:  ctl.rf_we = 1'b0;
        endcase
    end

endmodule

// File: rtl/tiny8_alu.sv
// Module: arithmetic, logic and shift unit. Combinational.
// Assumes: a is the destination operand, b the source operand; shift amounts
// of DATA_W or more saturate (zero for logical, sign fill for arithmetic).
module tiny8_alu
    import tiny8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result
);

    localparam int SHW = $clog2(DATA_W);

    logic                     big;
    logic [SHW-1:0]           shamt;
    logic signed [DATA_W-1:0] sra_raw;

    assign big     = |b[DATA_W-1:SHW];
    assign shamt   = b[SHW-1:0];
    assign sra_raw = $signed(a) >>> shamt;

    // Select the operation result for the current opcode.
    always_comb begin
        unique case (op)
            OP_MOV:  result = b;
            OP_ADD:  result = a + b;
            OP_SUB:  result = a - b;
            OP_AND:  result = a & b;
            OP_OR:   result = a | b;
            OP_NOT:  result = ~b;
            OP_SLL:  result = big ? '0 : (a << shamt);
            OP_SRL:  result = big ? '0 : (a >> shamt);
            OP_SRA:  result = big ? {DATA_W{a[DATA_W-1]}} : sra_raw;
            default: result = a;
        endcase
    end

    // Saturated shifts never leave partial bits behind (R4).
    always_comb begin
        if ((op == OP_SRL || op == OP_SLL) && big)
            a_r4_logic_shift_sat: assert ($countones(result) == 0);
        if (op == OP_SRA && big)
            a_r4_arith_shift_sat: assert ($countones(result) == 0 || $countones(result) == DATA_W);
    end

endmodule

// File: rtl/tiny8_regfile.sv
// Module: general register file with two combinational read ports and one
// synchronous write port. Synchronous active-low reset clears all entries.
module tiny8_regfile
    import tiny8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  wsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  rsel_a,
    input  logic [IDX_W-1:0]  rsel_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);

    logic [NREG-1:0][DATA_W-1:0] regs;

    // Clear on reset, otherwise write the selected entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (we) begin
            regs[wsel] <= wdata;
        end
    end

    assign rdata_a = regs[rsel_a];
    assign rdata_b = regs[rsel_b];

    // Without a write strobe the contents hold, e.g. on compare (R7).
    a_r7_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> regs == $past(regs));

endmodule

// File: rtl/tiny8_core.sv
// Module: tiny8 processor core top. One instruction per cycle: combinational
// fetch at the PC, decode, execute, and register/PC update at the clock edge.
// Assumes: instruction and data memories answer combinationally; one
// interrupt request, taken between instructions while unmasked.
module tiny8_core
    import tiny8_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter logic [7:0]  IRQ_VECTOR = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DATA_W-1:0] instr_addr,
    input  logic [7:0]        instr_data,
    output logic [DATA_W-1:0] dmem_addr,
    output logic [DATA_W-1:0] dmem_wdata,
    output logic              dmem_we,
    input  logic [DATA_W-1:0] dmem_rdata,
    input  logic              irq
);

    ctrl_t             ctl;
    logic [IDX_W-1:0]  dsel;
    logic [IDX_W-1:0]  ssel;
    logic [3:0]        imm4;

    logic [DATA_W-1:0] pc;
    logic              flag;
    logic [DATA_W-1:0] imm_q;
    logic [DATA_W-1:0] ret_q;
    logic              irq_mask;

    logic [DATA_W-1:0] dst_val;
    logic [DATA_W-1:0] rf_src;
    logic [DATA_W-1:0] src_val;
    logic [DATA_W-1:0] alu_res;
    logic [DATA_W-1:0] wb_val;
    logic [DATA_W-1:0] exec_next;
    logic              take_irq;

    tiny8_decode i_decode (
        .instr (instr_data),
        .ctl   (ctl),
        .dsel  (dsel),
        .ssel  (ssel),
        .imm4  (imm4)
    );

    tiny8_regfile #(.DATA_W(DATA_W)) i_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctl.rf_we),
        .wsel    (dsel),
        .wdata   (wb_val),
        .rsel_a  (dsel),
        .rsel_b  (ssel),
        .rdata_a (dst_val),
        .rdata_b (rf_src)
    );

    tiny8_alu #(.DATA_W(DATA_W)) i_alu (
        .op     (ctl.op),
        .a      (dst_val),
        .b      (src_val),
        .result (alu_res)
    );

    // Source index 3 is the immediate register; destination index 3 stays r3.
    assign src_val = (ssel == IMM_IDX) ? imm_q : rf_src;
    assign wb_val  = ctl.from_mem ? dmem_rdata : alu_res;

    assign instr_addr = pc;
    assign dmem_addr  = src_val;
    assign dmem_wdata = dst_val;
    assign dmem_we    = ctl.is_st;

    assign take_irq = irq && !irq_mask;

    // Next PC of the executing instruction, before any interrupt redirect.
    always_comb begin
        if (ctl.is_jmp || (ctl.is_je && flag))
            exec_next = src_val;
        else if (ctl.is_iret)
            exec_next = ret_q;
        else
            exec_next = pc + 1'b1;
    end

    // Update PC, flag, immediate, return address and interrupt mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= '0;
            flag     <= 1'b0;
            imm_q    <= '0;
            ret_q    <= '0;
            irq_mask <= 1'b0;
        end else begin
            if (ctl.is_cmp)  flag        <= (dst_val == src_val);
            if (ctl.is_ldih) imm_q[7:4]  <= imm4;
            if (ctl.is_ldil) imm_q[3:0]  <= imm4;
            if (take_irq) begin
                pc       <= IRQ_VECTOR;
                ret_q    <= exec_next;
                irq_mask <= 1'b1;
            end else begin
                pc <= exec_next;
                if (ctl.is_iret) irq_mask <= 1'b0;
            end
        end
    end

    // Interrupt entry goes to the vector with further requests masked (R11).
    a_r11_irq_entry: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> (pc == IRQ_VECTOR) && irq_mask);

    // The return resumes at the saved address and unmasks (R12).
    a_r12_iret_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.is_iret && !take_irq) |=> (pc == $past(ret_q)) && !irq_mask);

    // Non-branching instructions step the PC by one (R13).
    a_r13_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_irq && !ctl.is_je && !ctl.is_jmp && !ctl.is_iret) |=> pc == $past(pc) + 1'b1);

    // A high-nibble load leaves the low nibble untouched (R6).
    a_r6_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.is_ldih |=> imm_q[3:0] == $past(imm_q[3:0]));

    // The write strobe accompanies only the store opcode (R10).
    always_comb begin
        if (rst_n)
            a_r10_store_only: assert (!dmem_we || instr_data[7:4] == 4'hF);
    end

endmodule

// File: tb/test_tiny8_core.sv
`timescale 1ns/1ps
module test_tiny8_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq = 1'b0;
    logic [7:0] instr_data = 8'h00;
    logic [7:0] instr_addr, dmem_addr, dmem_wdata, dmem_rdata;
    logic       dmem_we;
    logic [7:0] dmem [256];

    int checks = 0;
    int errors = 0;

    tiny8_core i_tiny8_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_addr (instr_addr),
        .instr_data (instr_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata),
        .irq        (irq)
    );

    always #2.5 clk = ~clk;

    assign dmem_rdata = dmem[dmem_addr];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step(logic [7:0] ins);
        @(negedge clk);
        instr_data = ins;
        @(posedge clk);
        #1;
    endtask

    task automatic set_reg(int r, logic [7:0] v);
        step({4'hC, v[7:4]});
        step({4'hD, v[3:0]});
        step({4'h0, 2'(r), 2'd3});
    endtask

    task automatic read_reg(int r, output logic [7:0] v);
        @(negedge clk);
        instr_data = {4'hF, 2'(r), 2'd0};
        #1;
        v = dmem_wdata;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] model(int op, int a, int b);
        int r;
        r = 0;
        case (op)
            0: r = b;
            1: r = a + b;
            2: r = a - b + 256;
            3: r = a & b;
            4: r = a | b;
            5: r = 255 - b;
            6: r = (b >= 8) ? 0 : a * (1 << b);
            7: r = (b >= 8) ? 0 : a / (1 << b);
            8: begin
                r = a;
                for (int k = 0; k < 8 && k < b; k++) r = (r / 2) + ((r >= 128) ? 128 : 0);
            end
            default: r = 0;
        endcase
        return 8'(r % 256);
    endfunction

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] p;
        string tag;
        for (int i = 0; i < 256; i++) dmem[i] = 8'(i ^ 8'hA5);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 pc", instr_addr, 8'h00);
        for (int r = 0; r < 4; r++) begin
            read_reg(r, v);
            chk("R1 reg", v, 8'h00);
        end
        p = instr_addr;
        step(8'hA0);                 // je r0 with flag clear
        chk("R1 flag clear", instr_addr, 8'(p + 1));
        step(8'h03);                 // mov r0, imm
        read_reg(0, v);
        chk("R1 imm clear", v, 8'h00);

        // R2 R3 R4: sweep operand pairs over all ALU/shift opcodes
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 20; j++) begin
                int a, b;
                a = i * 17;
                b = (j < 10) ? j : ((j * 29) % 256);
                set_reg(1, 8'(b));
                for (int op = 0; op < 9; op++) begin
                    set_reg(0, 8'(a));
                    step({4'(op), 2'd0, 2'd1});
                    read_reg(0, v);
                    if (op == 0 || op == 5) tag = "R2";
                    else if (op <= 4) tag = "R3";
                    else tag = "R4";
                    chk(tag, v, model(op, a, b));
                end
            end
        end

        // R5: destination 3 is r3, source 3 is the immediate
        set_reg(3, 8'h77);
        step(8'hC2);                 // imm high nibble -> 2
        read_reg(3, v);
        chk("R5 dst r3", v, 8'h77);
        step(8'h03);
        read_reg(0, v);
        chk("R5 src imm", v, 8'h27);

        // R6: nibble loads keep the other nibble
        set_reg(0, 8'h5A);
        step(8'hC3);
        step(8'h03);
        read_reg(0, v);
        chk("R6 high", v, 8'h3A);
        step(8'hDC);
        step(8'h03);
        read_reg(0, v);
        chk("R6 low", v, 8'h3C);

        // R7 R8: compare and branches
        set_reg(2, 8'h40);
        set_reg(0, 8'h05);
        set_reg(1, 8'h05);
        step(8'h91);                 // cmp r0, r1
        read_reg(0, v);
        chk("R7 no write r0", v, 8'h05);
        read_reg(1, v);
        chk("R7 no write r1", v, 8'h05);
        step(8'hA2);                 // je r2, equal
        chk("R8 je taken", instr_addr, 8'h40);
        set_reg(1, 8'h06);
        step(8'h91);
        p = instr_addr;
        step(8'hA2);
        chk("R7 R8 je not taken", instr_addr, 8'(p + 1));
        step(8'hB2);                 // jmp r2
        chk("R8 jmp", instr_addr, 8'h40);

        // R9: undefined branch encodings are no-ops, flag set
        set_reg(1, 8'h05);
        step(8'h91);
        p = instr_addr;
        step(8'hA6);
        chk("R9 A6", instr_addr, 8'(p + 1));
        step(8'hBA);
        chk("R9 BA", instr_addr, 8'(p + 2));
        step(8'hB5);
        chk("R9 B5", instr_addr, 8'(p + 3));

        // R10: load and store
        set_reg(1, 8'h33);
        dmem[8'h33] = 8'h9C;
        @(negedge clk);
        instr_data = 8'hE9;          // ld r2, r1
        #1;
        chk("R10 ld addr", dmem_addr, 8'h33);
        chk("R10 ld no we", {7'd0, dmem_we}, 8'h00);
        @(posedge clk);
        #1;
        read_reg(2, v);
        chk("R10 ld data", v, 8'h9C);
        set_reg(0, 8'h5E);
        @(negedge clk);
        instr_data = 8'hF1;          // st r0, r1
        #1;
        chk("R10 st we", {7'd0, dmem_we}, 8'h01);
        chk("R10 st addr", dmem_addr, 8'h33);
        @(posedge clk);
        #1;
        chk("R10 st mem", dmem[8'h33], 8'h5E);

        // R11 R12: interrupt entry, masking, return
        set_reg(2, 8'h40);
        set_reg(0, 8'h21);
        p = instr_addr;
        irq = 1'b1;
        step(8'h10);                 // add r0, r0 completes
        chk("R11 vector", instr_addr, 8'hF0);
        step(8'h00);
        chk("R11 masked", instr_addr, 8'hF1);
        irq = 1'b0;
        step(8'hB4);
        chk("R12 return", instr_addr, 8'(p + 1));
        irq = 1'b1;
        step(8'hB2);                 // jmp r2 with request pending
        chk("R11 R12 unmasked vector", instr_addr, 8'hF0);
        irq = 1'b0;
        step(8'hB4);
        chk("R11 return to jump target", instr_addr, 8'h40);
        read_reg(0, v);
        chk("R11 instr completed", v, 8'h42);
        p = instr_addr;
        step(8'h30);
        chk("R13 step", instr_addr, 8'(p + 1));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule